// File: doc/BRIEF.md
# Serial Read-Memory Responder with CRC-16

This block is the slave side of a bit-serial memory read transaction. The bus master first writes a command byte and then a 16-bit start address, one bit per valid strobe. The block then returns one bit of a 128-byte memory on each read-slot strobe. It starts at the requested byte and runs through the last byte of memory. Every byte moves least significant bit first in both directions. The slot timing of the physical wire is handled elsewhere: this block sees only qualified bit strobes.

When streaming reaches the end of memory, the next sixteen read slots return a CRC-16. The CRC covers the command byte, both address bytes and every data byte that was actually returned. After that the response line stays high. A bus reset returns the engine to command reception from any phase. If the reset arrives before the end of memory, no CRC is ever sent. Any command byte other than the read opcode sends the engine to an idle state that answers with 1s. The memory itself lives outside the block and is read through an asynchronous port.

Top module: `rdMemEngine`

## Requirements
- R1: After `rstN` is deasserted or after a `busReset` pulse, the engine waits for a command byte, and `rspBit` is 1.
- R2: Incoming bits are taken on cycles with `wrValid` high, least significant bit first. The first byte is the command, and the value 0xF0 selects the read operation. The next two bytes are the address: the low byte first, then the high byte.
- R3: After the third byte, each `rdSlot` pulse returns one data bit, least significant bit first. Streaming starts at the start address and runs to byte 127. `rspBit` takes the new bit on the clock edge that samples `rdSlot` and holds it until the next slot.
- R4: Only address bits 6:0 select the start byte. Bit 7 of the low address byte and the whole high address byte have no effect on the data returned.
- R5: The sixteen read slots after the last bit of byte 127 return a CRC, least significant bit first. The CRC is the reflected polynomial 0xA001 (x^16+x^15+x^2+1), cleared to 0 and fed one bit at a time in wire order. It runs over the command byte, the low and high address bytes, and every data byte sent.
- R6: After the CRC, every read slot returns 1 until a reset.
- R7: A `busReset` in the middle of the data stream aborts the read. The next command starts with a cleared CRC and a fresh address.
- R8: A command byte other than 0xF0 makes every later read slot return 1, and all further written bits are ignored until a reset.
- R9: Read slots during the command and address phases return 1. `wrValid` pulses during the data phase do not change the bits returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busReset | input | 1 | One-cycle bus reset pulse, aborts any operation |
| wrValid | input | 1 | Master-written bit is valid this cycle |
| wrBit | input | 1 | Master-written bit value |
| rdSlot | input | 1 | Read slot strobe, one response bit per pulse |
| memAddr | output | 7 | Byte address of the external memory read port |
| memData | input | 8 | Byte returned by the memory for `memAddr` (asynchronous read) |
| rspBit | output | 1 | Response bit for the latest read slot |

## Verification
A wrong address counter or bit index shows up as a corrupted byte on the very first read slot it affects. A wrong CRC register, or a wrong choice of which bytes feed it, stays hidden until the sixteen slots after byte 127. A CRC state left over from an aborted read shows up in the CRC of the next complete read. The bench sweeps many start addresses and sets the ignored address bits in varied patterns. It also aborts a read partway through, sends a bad opcode, and sends bits during the wrong phases, so that each of these faults reaches `rspBit` within one transaction.

// File: rtl/rdMemPkg.sv
package rdMemPkg;

  typedef enum logic [2:0] {
    PH_CMD   = 3'd0,
    PH_ADRLO = 3'd1,
    PH_ADRHI = 3'd2,
    PH_DATA  = 3'd3,
    PH_CRC   = 3'd4,
    PH_ONES  = 3'd5
  } phase_e;

  typedef struct packed {
    logic clearAll;
    logic takeBit;
    logic loadAddr;
    logic sendData;
    logic sendCrc;
    logic sendOne;
  } dpStrobe_t;

endpackage

// File: rtl/rdMemCtrl.sv
module rdMemCtrl
  import rdMemPkg::*;
#(
  parameter int          BYTE_W   = 8,
  parameter logic [7:0]  READ_CMD = 8'hF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReset,
  input  logic              wrValid,
  input  logic              rdSlot,
  input  logic              rxLast,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              lastDataBit,
  input  logic              lastCrcBit,
  output dpStrobe_t         str,
  output phase_e            phase
);

  phase_e phaseNext;
  logic   byteDone;

  assign byteDone = wrValid && rxLast;

  always_comb begin
    str       = '0;
    phaseNext = phase;
    if (busReset) begin
      str.clearAll = 1'b1;
      phaseNext    = PH_CMD;
    end else begin
      unique case (phase)
        PH_CMD: begin
          str.takeBit = wrValid;
          str.sendOne = rdSlot;
          if (byteDone) begin
            phaseNext = (rxByte == READ_CMD) ? PH_ADRLO : PH_ONES;
          end
        end
        PH_ADRLO: begin
          str.takeBit = wrValid;
          str.sendOne = rdSlot;
          if (byteDone) begin
            str.loadAddr = 1'b1;
            phaseNext    = PH_ADRHI;
          end
        end
        PH_ADRHI: begin
          str.takeBit = wrValid;
          str.sendOne = rdSlot;
          if (byteDone) phaseNext = PH_DATA;
        end
        PH_DATA: begin
          str.sendData = rdSlot;
          if (rdSlot && lastDataBit) phaseNext = PH_CRC;
        end
        PH_CRC: begin
          str.sendCrc = rdSlot;
          if (rdSlot && lastCrcBit) phaseNext = PH_ONES;
        end
        PH_ONES: begin
          str.sendOne = rdSlot;
        end
        default: phaseNext = PH_CMD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_CMD;
    else       phase <= phaseNext;
  end

  // R1
  bus_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> (phase == PH_CMD));

  // R9
  one_driver_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({str.sendData, str.sendCrc, str.sendOne}));

  // R6
  ones_after_crc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_CRC && rdSlot && lastCrcBit && !busReset) |=> (phase == PH_ONES));

  // R8
  ones_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ONES && !busReset) |=> (phase == PH_ONES));

endmodule

// File: rtl/rdMemDatapath.sv
module rdMemDatapath
  import rdMemPkg::*;
#(
  parameter int          ADDR_W   = 7,
  parameter int          BYTE_W   = 8,
  parameter int          CRC_W    = 16,
  parameter logic [15:0] CRC_POLY = 16'hA001
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         str,
  input  logic              wrBit,
  input  logic [BYTE_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              rxLast,
  output logic [BYTE_W-1:0] rxByte,
  output logic              lastDataBit,
  output logic              lastCrcBit,
  output logic              rspBit
);

  localparam int BIT_IDX_W = $clog2(BYTE_W);
  localparam int CRC_IDX_W = $clog2(CRC_W);
  localparam logic [ADDR_W-1:0]    LAST_ADDR = '1;
  localparam logic [BIT_IDX_W-1:0] LAST_BIT  = BIT_IDX_W'(BYTE_W - 1);
  localparam logic [CRC_IDX_W-1:0] LAST_CRC  = CRC_IDX_W'(CRC_W - 1);

  logic [BYTE_W-1:0]    rxShift;
  logic [BIT_IDX_W-1:0] rxCnt;
  logic [ADDR_W-1:0]    addrReg;
  logic [BIT_IDX_W-1:0] txIdx;
  logic [CRC_W-1:0]     crcReg;
  logic [CRC_IDX_W-1:0] crcIdx;
  logic                 dataBit;

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] c, input logic b);
    logic [CRC_W-1:0] s;
    s = c >> 1;
    if (c[0] ^ b) s = s ^ CRC_POLY[CRC_W-1:0];
    return s;
  endfunction

  assign rxByte      = {wrBit, rxShift[BYTE_W-1:1]};
  assign rxLast      = (rxCnt == LAST_BIT);
  assign dataBit     = memData[txIdx];
  assign lastDataBit = (txIdx == LAST_BIT) && (addrReg == LAST_ADDR);
  assign lastCrcBit  = (crcIdx == LAST_CRC);
  assign memAddr     = addrReg;

  // receive shifter and bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxCnt   <= '0;
    end else if (str.clearAll) begin
      rxShift <= '0;
      rxCnt   <= '0;
    end else if (str.takeBit) begin
      rxShift <= rxByte;
      rxCnt   <= rxCnt + 1'b1;
    end
  end

  // address and transmit bit index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      txIdx   <= '0;
    end else if (str.clearAll) begin
      addrReg <= '0;
      txIdx   <= '0;
    end else if (str.loadAddr) begin
      addrReg <= rxByte[ADDR_W-1:0];
      txIdx   <= '0;
    end else if (str.sendData) begin
      txIdx <= txIdx + 1'b1;
      if (txIdx == LAST_BIT) addrReg <= addrReg + 1'b1;
    end
  end

  // CRC generator and CRC bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg <= '0;
      crcIdx <= '0;
    end else if (str.clearAll) begin
      crcReg <= '0;
      crcIdx <= '0;
    end else if (str.takeBit) begin
      crcReg <= crcStep(crcReg, wrBit);
    end else if (str.sendData) begin
      crcReg <= crcStep(crcReg, dataBit);
    end else if (str.sendCrc) begin
      crcReg <= crcReg >> 1;
      crcIdx <= crcIdx + 1'b1;
    end
  end

  // response bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspBit <= 1'b1;
    end else if (str.clearAll || str.sendOne) begin
      rspBit <= 1'b1;
    end else if (str.sendData) begin
      rspBit <= dataBit;
    end else if (str.sendCrc) begin
      rspBit <= crcReg[0];
    end
  end

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(str.sendData || str.loadAddr || str.clearAll) |=> $stable(addrReg));

  // R1
  clear_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.clearAll |=> (rspBit && crcReg == '0 && crcIdx == '0));

  // R5
  crc_idx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(str.sendCrc || str.clearAll) |=> $stable(crcIdx));

endmodule

// File: rtl/rdMemEngine.sv
module rdMemEngine
  import rdMemPkg::*;
#(
  parameter int          ADDR_W   = 7,
  parameter int          BYTE_W   = 8,
  parameter int          CRC_W    = 16,
  parameter logic [15:0] CRC_POLY = 16'hA001,
  parameter logic [7:0]  READ_CMD = 8'hF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReset,
  input  logic              wrValid,
  input  logic              wrBit,
  input  logic              rdSlot,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [BYTE_W-1:0] memData,
  output logic              rspBit
);

  dpStrobe_t         str;
  phase_e            phase;
  logic              rxLast;
  logic [BYTE_W-1:0] rxByte;
  logic              lastDataBit;
  logic              lastCrcBit;

  rdMemCtrl #(
    .BYTE_W  (BYTE_W),
    .READ_CMD(READ_CMD)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busReset   (busReset),
    .wrValid    (wrValid),
    .rdSlot     (rdSlot),
    .rxLast     (rxLast),
    .rxByte     (rxByte),
    .lastDataBit(lastDataBit),
    .lastCrcBit (lastCrcBit),
    .str        (str),
    .phase      (phase)
  );

  rdMemDatapath #(
    .ADDR_W  (ADDR_W),
    .BYTE_W  (BYTE_W),
    .CRC_W   (CRC_W),
    .CRC_POLY(CRC_POLY)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .str        (str),
    .wrBit      (wrBit),
    .memData    (memData),
    .memAddr    (memAddr),
    .rxLast     (rxLast),
    .rxByte     (rxByte),
    .lastDataBit(lastDataBit),
    .lastCrcBit (lastCrcBit),
    .rspBit     (rspBit)
  );

  // R8
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ONES && rdSlot && !busReset) |=> rspBit);

  // R9
  cmd_phase_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase inside {PH_CMD, PH_ADRLO, PH_ADRHI}) |-> rspBit);

endmodule

// File: tb/rdMemEngine_tb.sv
module rdMemEngine_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busReset = 1'b0;
  logic       wrValid = 1'b0;
  logic       wrBit = 1'b0;
  logic       rdSlot = 1'b0;
  logic [6:0] memAddr;
  logic [7:0] memData;
  logic       rspBit;

  int  errors = 0;
  int  checks = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [7:0] memByte(input int a);
    return 8'(((a * 37) + 11) ^ (a >> 3));
  endfunction

  assign memData = memByte(int'(memAddr));

  rdMemEngine u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .busReset(busReset),
    .wrValid (wrValid),
    .wrBit   (wrBit),
    .rdSlot  (rdSlot),
    .memAddr (memAddr),
    .memData (memData),
    .rspBit  (rspBit)
  );

  function automatic logic [15:0] refCrcByte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ 16'hA001;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      wrValid = 1'b1;
      wrBit   = b[i];
    end
    @(negedge clk);
    wrValid = 1'b0;
    wrBit   = 1'b0;
  endtask

  task automatic slot(output logic v);
    @(negedge clk);
    rdSlot = 1'b1;
    @(negedge clk);
    rdSlot = 1'b0;
    v = rspBit;
  endtask

  task automatic readByte(output logic [7:0] b);
    logic v;
    for (int i = 0; i < 8; i++) begin
      slot(v);
      b[i] = v;
    end
  endtask

  task automatic pulseBusReset();
    @(negedge clk);
    busReset = 1'b1;
    @(negedge clk);
    busReset = 1'b0;
  endtask

  // full read from start lo/hi, checks data, CRC and trailing ones
  task automatic fullRead(input logic [7:0] lo, input logic [7:0] hi);
    logic [15:0] crc;
    logic [7:0]  got;
    logic [15:0] crcGot;
    logic        v;
    int          bad;
    pulseBusReset();
    sendByte(8'hF0);
    sendByte(lo);
    sendByte(hi);
    crc = refCrcByte(16'h0, 8'hF0);
    crc = refCrcByte(crc, lo);
    crc = refCrcByte(crc, hi);
    for (int a = int'(lo[6:0]); a < 128; a++) begin
      readByte(got);
      // R3 R4: data from start byte (bits 6:0 only) to byte 127
      check(got == memByte(a), "R3/R4 data byte", int'(got), int'(memByte(a)));
      crc = refCrcByte(crc, memByte(a));
    end
    for (int i = 0; i < 16; i++) begin
      slot(v);
      crcGot[i] = v;
    end
    // R5: CRC over command, address and streamed data
    check(crcGot == crc, "R5 crc", int'(crcGot), int'(crc));
    bad = 0;
    for (int i = 0; i < 4; i++) begin
      slot(v);
      if (v !== 1'b1) bad++;
    end
    // R6: ones after CRC
    check(bad == 0, "R6 ones after crc", bad, 0);
  endtask

  initial begin
    logic [7:0] got;
    logic       v;
    int         bad;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rspBit == 1'b1, "R1 rspBit after rstN", int'(rspBit), 1);
    rstN = 1'b1;
    @(negedge clk);
    check(rspBit == 1'b1, "R1 rspBit idle", int'(rspBit), 1);

    // R2 R3 R4 R5 R6: sweep of start addresses with varied ignored bits
    for (int a = 0; a < 128; a += 5) begin
      fullRead(8'(a | ((a & 1) << 7)), 8'((a * 3) & 255));
    end
    fullRead(8'd127, 8'hFF);
    fullRead(8'hFE, 8'h00);

    // R9: read slots during command/address phase return 1
    pulseBusReset();
    slot(v);
    check(v == 1'b1, "R9 slot in command phase", int'(v), 1);
    sendByte(8'hF0);
    slot(v);
    check(v == 1'b1, "R9 slot in address phase", int'(v), 1);
    sendByte(8'd100);
    sendByte(8'd0);
    // R9: written bits during data phase are ignored
    readByte(got);
    check(got == memByte(100), "R9 data before junk", int'(got), int'(memByte(100)));
    sendByte(8'hA5);
    readByte(got);
    check(got == memByte(101), "R9 data after junk", int'(got), int'(memByte(101)));

    // R7: abort mid stream, then a fresh full read
    pulseBusReset();
    sendByte(8'hF0);
    sendByte(8'd5);
    sendByte(8'd0);
    for (int i = 0; i < 3; i++) readByte(got);
    pulseBusReset();
    slot(v);
    check(v == 1'b1, "R7 after abort high", int'(v), 1);
    fullRead(8'd120, 8'd0);

    // R8: bad command gives ones, even after more bytes
    pulseBusReset();
    sendByte(8'hAA);
    sendByte(8'hF0);
    sendByte(8'd0);
    sendByte(8'd0);
    bad = 0;
    for (int i = 0; i < 24; i++) begin
      slot(v);
      if (v !== 1'b1) bad++;
    end
    check(bad == 0, "R8 bad command ones", bad, 0);
    // R1: busReset recovers from idle
    fullRead(8'd124, 8'd1);

    // R1: rstN mid stream recovers
    pulseBusReset();
    sendByte(8'hF0);
    sendByte(8'd10);
    sendByte(8'd0);
    readByte(got);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(rspBit == 1'b1, "R1 rspBit in rstN", int'(rspBit), 1);
    rstN = 1'b1;
    fullRead(8'd126, 8'd0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule